// File: doc/BRIEF.md
# Framed Word Serializer

This block is the sending half of a 24-bit serial link. A parallel word is taken in on the rising edge of a strobe. It is then sent one bit at a time on a single data line. A forwarded clock goes out with the data and stays source-synchronous with it. Each word occupies 26 bit slots: 24 data slots and two marker slots. The word boundary is encoded in the forwarded clock itself, which stays high through the marker slots. The receiver therefore needs no separate framing wire.

The block runs from a system clock. A one-cycle `bit_en` pulse from the surrounding clock logic paces it. Each slot lasts two `bit_en` pulses: in the first half the forwarded clock is low, and in the second half it is high. A receiver therefore samples data on the rising edge of the forwarded clock. The role input is sampled while reset is held. When it is low, the block acts as a receiver-side part, drives both lines low and ignores strobes. When no word is waiting at a word start, an idle word is sent: the clock keeps toggling, the data stays low and no boundary marker appears.

Top module: `word_serializer`

## Requirements
- R1: While `rst` is high, and up to the first `bit_en` pulse after it, `ser_data` and `fwd_clk` are both 0.
- R2: `word_in` is captured on the clock edge where `strobe` is first seen high after being low. Later changes of `word_in` do not alter the word that is sent.
- R3: A word is 26 slots and each slot is two `bit_en` pulses long. In a toggling slot, `fwd_clk` is 0 in the first half and 1 in the second half. `ser_data` changes only at slot starts.
- R4: In a framed word, slots 0 to 23 carry `word_in` bit 23 down to bit 0 (MSB first).
- R5: In slots 24 and 25 of a framed word, `fwd_clk` is 1 in both halves and `ser_data` is 0. Each strobe produces exactly one such boundary.
- R6: A word that starts with no captured strobe pending is idle: `fwd_clk` toggles in all 26 slots and `ser_data` is 0 throughout.
- R7: When several strobes arrive within one word, only the last captured value is sent, and it is sent as a single framed word.
- R8: A strobe held high over several words yields only one framed word.
- R9: `dir_tx` is sampled only while `rst` is high. If it was 0, both outputs stay 0 and strobes are ignored until the next reset. Changes of `dir_tx` outside reset have no effect.
- R10: The outputs change only on the clock edge one cycle after a `bit_en` pulse. While `bit_en` stays low, they hold their values.
- R11: A strobe at any point of a word, even in its last slot, is sent in the next word. The first word after reset starts on the second `bit_en` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | Role select, sampled during reset: 1 sends, 0 stays quiet |
| bit_en | input | 1 | One-cycle pulse per half bit slot |
| strobe | input | 1 | Word capture strobe, rising edge active |
| word_in | input | WORD_W | Parallel word to send |
| ser_data | output | 1 | Serial data, MSB first |
| fwd_clk | output | 1 | Forwarded bit clock carrying the word boundary |

## Verification
The state machine moves on the edge that samples a `bit_en` pulse, and the output registers show the new state one clock later. The bench therefore reads both lines at the falling edge two clocks after each pulse, well before the next pulse four clocks away. Its own pulse count places each sample at a fixed slot and half: the first word starts at pulse 2, and each later word starts 52 pulses after the one before. A strobe is therefore expected in the word that follows the one in which it was raised. Strobes are placed at known half-slots, never on a word-start edge, so every expected word number is exact.

// File: rtl/wser_pkg.sv
package wser_pkg;
  // one output sample of the link: forwarded clock and data
  typedef struct packed {
    logic fwd;
    logic dat;
  } line_t;

  localparam logic LINE_IDLE = 1'b0;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOTS = 26
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  output logic                     phase,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic                     word_start,
  output logic                     slot_adv
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  // a slot ends when the high half is left
  assign word_start = tick & phase & (slot == LAST);
  assign slot_adv   = tick & phase & (slot != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      slot  <= LAST;
    end else if (tick) begin
      phase <= ~phase;
      if (phase) slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end
  end

  // R3: the slot counter never leaves its 26-slot range
  a_r3_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST);

  // R3: a slot advances only after a half-slot pulse
  a_r3_slot_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(slot));
endmodule

// File: rtl/strobe_catch.sv
module strobe_catch #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_start,
  output logic [WORD_W-1:0] hold,
  output logic              pending
);
  logic strobe_q;
  logic rise;

  assign rise = enable & strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      pending  <= 1'b0;
      hold     <= '0;
    end else begin
      strobe_q <= strobe;
      // a fresh edge wins over the word start that empties the slot
      if (rise) begin
        hold    <= word_in;
        pending <= 1'b1;
      end else if (word_start) begin
        pending <= 1'b0;
      end
    end
  end

  // R2: an edge stores the word present on that cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    rise |=> pending && (hold == $past(word_in)));

  // R11: a waiting word survives until a word start takes it
  a_r11_pending_kept: assert property (@(posedge clk) disable iff (rst)
    pending && !word_start |=> pending);
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import wser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SLOTS  = 26
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_start,
  input  logic                     slot_adv,
  input  logic                     phase,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic [WORD_W-1:0]        hold,
  input  logic                     pending,
  output logic                     ser_data,
  output logic                     fwd_clk
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] FIRST_MARK = SW'(WORD_W);

  logic [WORD_W-1:0] sh;
  logic              frame_active;
  line_t             nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      frame_active <= 1'b0;
    end else if (word_start) begin
      frame_active <= pending;
      sh           <= pending ? hold : '0;
    end else if (slot_adv) begin
      sh <= {sh[WORD_W-2:0], 1'b0};
    end
  end

  always_comb begin
    nxt.fwd = (frame_active && slot >= FIRST_MARK) ? 1'b1 : phase;
    nxt.dat = (frame_active && slot < FIRST_MARK) ? sh[WORD_W-1] : LINE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      fwd_clk  <= 1'b0;
    end else begin
      ser_data <= nxt.dat;
      fwd_clk  <= nxt.fwd;
    end
  end

  // R6: no framed word means a low data line
  a_r6_idle_data_low: assert property (@(posedge clk) disable iff (rst)
    !frame_active |=> !ser_data);

  // R5: marker slots hold the forwarded clock high and data low
  a_r5_marker_high: assert property (@(posedge clk) disable iff (rst)
    frame_active && (slot >= FIRST_MARK) |=> fwd_clk && !ser_data);
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W     = 24,
  parameter int MARK_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_tx,
  input  logic              bit_en,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_data,
  output logic              fwd_clk
);
  localparam int SLOTS = WORD_W + MARK_SLOTS;
  localparam int SW    = $clog2(SLOTS);

  generate
    if (MARK_SLOTS < 1 || WORD_W < 2) begin : g_bad_cfg
      $error("word_serializer needs WORD_W >= 2 and MARK_SLOTS >= 1");
    end
  endgenerate

  logic              role_tx;
  logic              tick;
  logic              phase;
  logic [SW-1:0]     slot;
  logic              word_start;
  logic              slot_adv;
  logic [WORD_W-1:0] hold;
  logic              pending;

  // role is taken only while reset is held
  always_ff @(posedge clk) begin
    if (rst) role_tx <= dir_tx;
  end

  assign tick = bit_en & role_tx;

  slot_timer #(.SLOTS(SLOTS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .phase(phase), .slot(slot),
    .word_start(word_start), .slot_adv(slot_adv)
  );

  strobe_catch #(.WORD_W(WORD_W)) u_catch (
    .clk(clk), .rst(rst), .enable(role_tx), .strobe(strobe),
    .word_in(word_in), .word_start(word_start), .hold(hold),
    .pending(pending)
  );

  word_shifter #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_shift (
    .clk(clk), .rst(rst), .word_start(word_start), .slot_adv(slot_adv),
    .phase(phase), .slot(slot), .hold(hold), .pending(pending),
    .ser_data(ser_data), .fwd_clk(fwd_clk)
  );

  // R9: a receiver-role part keeps both lines low
  a_r9_rx_quiet: assert property (@(posedge clk) disable iff (rst)
    !role_tx |-> !fwd_clk && !ser_data);

  // R10: outputs hold when no pulse arrived two edges back
  a_r10_hold_fwd: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en, 2) |-> $stable(fwd_clk));

  a_r10_hold_dat: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en, 2) |-> $stable(ser_data));
endmodule

// File: tb/test_word_serializer.sv
module test_word_serializer;
  localparam int W      = 24;
  localparam int HALVES = 52;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dir_tx = 1'b1;
  logic         bit_en = 1'b0;
  logic         strobe = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         ser_data;
  logic         fwd_clk;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  word_serializer i_word_serializer (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .bit_en(bit_en),
    .strobe(strobe), .word_in(word_in), .ser_data(ser_data),
    .fwd_clk(fwd_clk)
  );

  // pulse generator: one pulse every four clocks
  logic run = 1'b1;
  int   div = 0;
  always @(negedge clk) begin
    if (run) begin
      bit_en = (div == 3);
      div    = (div + 1) % 4;
    end else begin
      bit_en = 1'b0;
    end
  end

  // monitor: map each pulse to a word and half slot
  int              n_tick = 0;
  int              cur_half = -1;
  int              cur_word = -1;
  int              done_word = -1;
  logic [HALVES-1:0] cur_f, cur_d, done_f, done_d;
  always begin
    @(posedge clk);
    if (rst) begin
      n_tick = 0; cur_half = -1; cur_word = -1; done_word = -1;
    end else if (bit_en) begin
      n_tick = n_tick + 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (n_tick >= 2) begin
        cur_half = (n_tick - 2) % HALVES;
        cur_word = (n_tick - 2) / HALVES;
        cur_f[cur_half] = fwd_clk;
        cur_d[cur_half] = ser_data;
        if (cur_half == HALVES - 1) begin
          done_f = cur_f; done_d = cur_d; done_word = cur_word;
        end
      end
    end
  end

  function automatic logic [HALVES-1:0] exp_fwd(input bit act);
    logic [HALVES-1:0] v;
    for (int h = 0; h < HALVES; h++)
      v[h] = (act && (h / 2) >= W) ? 1'b1 : logic'(h % 2);
    return v;
  endfunction

  function automatic logic [HALVES-1:0] exp_dat(input bit act, input logic [W-1:0] wd);
    logic [HALVES-1:0] v;
    for (int h = 0; h < HALVES; h++)
      v[h] = (act && (h / 2) < W) ? wd[W-1-(h/2)] : 1'b0;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [HALVES-1:0] act_v, input logic [HALVES-1:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act_v, exp_v);
    end
  endtask

  task automatic wait_half(input int h);
    while (cur_half == h) @(negedge clk);
    while (cur_half != h) @(negedge clk);
  endtask

  task automatic pulse_strobe(input logic [W-1:0] v);
    word_in = v;
    strobe  = 1'b1;
    repeat (2) @(negedge clk);
    strobe  = 1'b0;
    word_in = ~v;       // later changes must not leak in (R2)
  endtask

  task automatic check_word(input int w, input bit act, input logic [W-1:0] v,
                            input string req);
    while (done_word < w) @(negedge clk);
    check(done_word == w, req, "word index", HALVES'(done_word), HALVES'(w));
    check(done_f == exp_fwd(act), req, "fwd_clk pattern", done_f, exp_fwd(act));
    check(done_d == exp_dat(act, v), req, "ser_data pattern", done_d, exp_dat(act, v));
  endtask

  task automatic do_reset(input logic d);
    @(negedge clk);
    rst = 1'b1; dir_tx = d;
    repeat (4) @(negedge clk);
    // R1: both lines low under reset
    check(!ser_data && !fwd_clk, "R1", "reset outputs", {ser_data, fwd_clk}, '0);
    rst = 1'b0;
  endtask

  // R1, R11, R6: first word after reset is idle and aligned
  task automatic t_reset;
    do_reset(1'b1);
    check_word(0, 1'b0, '0, "R11");
  endtask

  // R2, R3, R4, R5: one word, then R6 idle
  task automatic t_single(input logic [W-1:0] v);
    int w0;
    wait_half(10); w0 = cur_word;
    pulse_strobe(v);
    check_word(w0 + 1, 1'b1, v, "R4");
    check_word(w0 + 2, 1'b0, '0, "R6");
  endtask

  // R7: latest of two strobes in one word
  task automatic t_latest;
    int w0;
    wait_half(6); w0 = cur_word;
    pulse_strobe(24'h123456);
    wait_half(20);
    pulse_strobe(24'hF0E1D2);
    check_word(w0 + 1, 1'b1, 24'hF0E1D2, "R7");
    check_word(w0 + 2, 1'b0, '0, "R7");
  endtask

  // R8: strobe held high gives one word
  task automatic t_level;
    int w0;
    wait_half(8); w0 = cur_word;
    word_in = 24'h5A5A0F;
    strobe  = 1'b1;
    repeat (2) @(negedge clk);
    word_in = 24'h000001;
    repeat (300) @(negedge clk);
    strobe = 1'b0;
    check_word(w0 + 1, 1'b1, 24'h5A5A0F, "R8");
    check_word(w0 + 2, 1'b0, '0, "R8");
  endtask

  // R11: strobe in the final slot still lands in the next word
  task automatic t_late;
    int w0;
    wait_half(50); w0 = cur_word;
    pulse_strobe(24'h800001);
    check_word(w0 + 1, 1'b1, 24'h800001, "R11");
  endtask

  // R10: stalled pulses freeze the lines
  task automatic t_stall;
    logic f0, d0;
    bit   same = 1'b1;
    wait_half(17);
    run = 1'b0;
    repeat (3) @(negedge clk);
    f0 = fwd_clk; d0 = ser_data;
    repeat (20) begin
      @(negedge clk);
      if (fwd_clk !== f0 || ser_data !== d0) same = 1'b0;
    end
    check(same, "R10", "outputs during stall", {fwd_clk, ser_data}, {f0, d0});
    run = 1'b1;
  endtask

  // R9: receiver role stays quiet, ignores strobes and later dir changes
  task automatic t_rx;
    int w0;
    do_reset(1'b0);
    dir_tx = 1'b1;
    wait_half(4); w0 = cur_word;
    pulse_strobe(24'hFFFFFF);
    while (done_word < w0 + 1) @(negedge clk);
    check(done_f == '0, "R9", "fwd_clk quiet", done_f, '0);
    check(done_d == '0, "R9", "ser_data quiet", done_d, '0);
    do_reset(1'b1);
    dir_tx = 1'b0;      // must not matter after reset
    t_single(24'h3C00C3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_single(24'hA5C396);
    t_latest;
    t_level;
    t_late;
    t_stall;
    t_single(24'hFFFFFF);
    t_rx;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule